// File: doc/BRIEF.md
# Sleep Wake-Up Sequencer

This block takes a processor subsystem into a low-power sleep state and brings it back. A pulse on the sleep request makes the block ask the CPU for its bus. Once the CPU grants the bus, the block asserts the system power-down signal. While asleep, the block watches a vector of interrupt request lines through a per-line enable mask. The CPU's own global interrupt enable has no part in this.

When any enabled request appears, the block runs a fixed wake sequence paced by a slow (nominally 32 kHz) clock, using both of its edges:

1. A falling edge registers the request.
2. The next rising edge releases power-down.
3. The rising edge after that raises a one-half-period strobe that samples the reference-voltage settle status.
4. The falling edge that follows raises a second one-half-period strobe. This strobe captures the supply-supervisor status. On the same edge the bus request drops, so the CPU releases its acknowledge and resumes.

The path from interrupt to release takes two to three slow-clock periods, depending on where the interrupt lands.

A two-bit status output shows whether the block is awake, entering sleep, asleep, or waking. The CPU-clock-domain inputs (sleep request and bus acknowledge) reach the slow-clock logic through multi-flop synchronizers. The interrupt is resolved by a falling-edge flop, followed by the rising-edge state register.

Top module: `sleep_wake_seq`

## Requirements
- R1: While reset is asserted and right after it, pwr_down, bus_req, ref_sample and sup_sample are 0, sup_held is all zeros, and seq_status is 2'b00 (awake).
- R2: A rising edge of sleep_req while awake raises bus_req and sets seq_status to 2'b01 (entering). Once bus_ack has been seen high, pwr_down rises and seq_status becomes 2'b10 (asleep).
- R3: While bus_ack stays low, pwr_down stays 0 and seq_status stays 2'b01, however long the wait.
- R4: pwr_down is never high while bus_req is low.
- R5: While asleep, a request line i wakes the block only if irq_req[i] and irq_mask[i] are both 1 (mask bit 1 = enabled). Requests on masked lines leave pwr_down at 1 and seq_status at 2'b10.
- R6: pwr_down falls on the first rising slow-clock edge after the falling edge that first sees an enabled request. At the same edge seq_status becomes 2'b11 (waking).
- R7: ref_sample rises on the next rising slow-clock edge and falls on the falling edge after it. It is high for exactly one half-period, once per wake.
- R8: On that falling edge, sup_sample rises for exactly one half-period, bus_req falls, and sup_held takes the value of sup_status. sup_held then holds that value, and seq_status returns to 2'b00 on the next rising edge.
- R9: ref_sample and sup_sample are never high together, and neither is high unless seq_status is 2'b11.
- R10: The time from an enabled request appearing to bus_req falling lies between two and three slow-clock periods.
- R11: Interrupt requests while awake have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU clock; used by the edge checks only |
| clk_slow | input | 1 | Slow sequencing clock, both edges used |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_mask | input | N_IRQ | Per-line wake enable, 1 = enabled |
| sleep_req | input | 1 | Sleep request from the CPU domain, acts on its rising edge |
| bus_ack | input | 1 | Bus acknowledge from the CPU |
| sup_status | input | N_SUP | Supply-supervisor status lines |
| pwr_down | output | 1 | System power-down |
| ref_sample | output | 1 | Reference-voltage sample strobe |
| sup_sample | output | 1 | Supervisor sample strobe |
| bus_req | output | 1 | Bus request to the CPU |
| sup_held | output | N_SUP | Supervisor status captured by the last wake |
| seq_status | output | 2 | 00 awake, 01 entering, 10 asleep, 11 waking |

## Verification
The properties run on every CPU clock and check the invariants that hold at all times. Power-down needs the bus request. The two strobes are exclusive and appear only while waking. The bus request falls only together with the supervisor strobe. Power-down rises only under an acknowledge and falls only into the waking state.

Other behaviour depends on the scenario and is shown only by the bench. This covers the exact edge at which each output moves, the half-period strobe widths, and the two-to-three-period wake latency. It also covers which mask patterns wake the block, the stall while the acknowledge is withheld, the held supervisor capture, and the absence of any effect from interrupts while awake.

// File: rtl/sws_pkg.sv
package sws_pkg;

   typedef enum logic [2:0] {
      ST_AWAKE  = 3'd0,
      ST_ENTER  = 3'd1,
      ST_SLEEP  = 3'd2,
      ST_SETTLE = 3'd3,
      ST_SAMPLE = 3'd4
   } sws_state_e;

   localparam logic [1:0] STAT_AWAKE  = 2'b00;
   localparam logic [1:0] STAT_ENTER  = 2'b01;
   localparam logic [1:0] STAT_ASLEEP = 2'b10;
   localparam logic [1:0] STAT_WAKING = 2'b11;

endpackage

// File: rtl/sws_sync.sv
module sws_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sws_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sws_wake_detect.sv
module sws_wake_detect #(
   parameter int N_IRQ            = 8,
   parameter bit MASK_ACTIVE_HIGH = 1'b1
) (
   input  logic             clk_slow,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_mask,
   output logic             wake_n
);

   logic [N_IRQ-1:0] enabled;

   if (MASK_ACTIVE_HIGH) begin : g_mask_high
      assign enabled = irq_req & irq_mask;
   end else begin : g_mask_low
      assign enabled = irq_req & ~irq_mask;
   end

   // first resolving flop on the falling edge; the rising-edge state
   // register behind it is the second
   always_ff @(negedge clk_slow or negedge rst_n) begin
      if (!rst_n) wake_n <= 1'b0;
      else        wake_n <= |enabled;
   end

endmodule

// File: rtl/sws_fsm.sv
module sws_fsm
   import sws_pkg::*;
(
   input  logic       clk_slow,
   input  logic       rst_n,
   input  logic       sleep_s,
   input  logic       ack_s,
   input  logic       wake_n,
   output sws_state_e state_q,
   output logic       pd_q
);

   sws_state_e state_d;
   logic       sleep_d;
   logic       sleep_rise;

   assign sleep_rise = sleep_s & ~sleep_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_AWAKE:  if (sleep_rise) state_d = ST_ENTER;
         ST_ENTER:  if (ack_s)      state_d = ST_SLEEP;
         ST_SLEEP:  if (wake_n)     state_d = ST_SETTLE;
         ST_SETTLE:                 state_d = ST_SAMPLE;
         ST_SAMPLE:                 state_d = ST_AWAKE;
         default:                   state_d = ST_AWAKE;
      endcase
   end

   always_ff @(posedge clk_slow or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_AWAKE;
         pd_q    <= 1'b0;
         sleep_d <= 1'b0;
      end else begin
         state_q <= state_d;
         pd_q    <= (state_d == ST_SLEEP);
         sleep_d <= sleep_s;
      end
   end

   // R6: release only leads into the settle step
   a_r6_release_to_settle: assert property (@(posedge clk_slow) disable iff (!rst_n)
      (state_q == ST_SLEEP && wake_n) |=> (!pd_q && state_q == ST_SETTLE));

endmodule

// File: rtl/sws_strobe.sv
module sws_strobe
   import sws_pkg::*;
#(
   parameter int N_SUP = 2
) (
   input  logic             clk_slow,
   input  logic             rst_n,
   input  sws_state_e       state_q,
   input  logic [N_SUP-1:0] sup_status,
   output logic             ref_sample,
   output logic             sup_sample,
   output logic             bus_req,
   output logic [N_SUP-1:0] sup_held
);

   logic ref_p, ref_n;
   logic sup_p, sup_n;
   logic breq_n;

   // rising-edge half of each strobe
   always_ff @(posedge clk_slow or negedge rst_n) begin
      if (!rst_n) begin
         ref_p <= 1'b0;
         sup_p <= 1'b0;
      end else begin
         ref_p <= (state_q == ST_SETTLE);
         sup_p <= sup_n;
      end
   end

   // falling-edge half, bus request and supervisor capture
   always_ff @(negedge clk_slow or negedge rst_n) begin
      if (!rst_n) begin
         ref_n    <= 1'b0;
         sup_n    <= 1'b0;
         breq_n   <= 1'b0;
         sup_held <= '0;
      end else begin
         ref_n <= ref_p;
         sup_n <= (state_q == ST_SAMPLE);
         if (state_q == ST_ENTER)       breq_n <= 1'b1;
         else if (state_q == ST_SAMPLE) breq_n <= 1'b0;
         if (state_q == ST_SAMPLE) sup_held <= sup_status;
      end
   end

   assign ref_sample = ref_p & ~ref_n;
   assign sup_sample = sup_n & ~sup_p;
   assign bus_req    = breq_n;

   // R7: the reference strobe is gone by the falling edge that raises the supervisor strobe
   a_r7_ref_half_period: assert property (@(negedge clk_slow) disable iff (!rst_n)
      ref_sample |=> !ref_sample);

endmodule

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq
   import sws_pkg::*;
#(
   parameter int N_IRQ            = 8,
   parameter int N_SUP            = 2,
   parameter int SYNC_STAGES      = 2,
   parameter bit MASK_ACTIVE_HIGH = 1'b1
) (
   input  logic             clk_cpu,
   input  logic             clk_slow,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_mask,
   input  logic             sleep_req,
   input  logic             bus_ack,
   input  logic [N_SUP-1:0] sup_status,
   output logic             pwr_down,
   output logic             ref_sample,
   output logic             sup_sample,
   output logic             bus_req,
   output logic [N_SUP-1:0] sup_held,
   output logic [1:0]       seq_status
);

   if (N_IRQ < 1) begin : g_bad_irq
      $error("sleep_wake_seq: N_IRQ must be at least 1");
   end
   if (N_SUP < 1) begin : g_bad_sup
      $error("sleep_wake_seq: N_SUP must be at least 1");
   end

   logic       sleep_s, ack_s, wake_n;
   sws_state_e state_q;

   sws_sync #(.STAGES(SYNC_STAGES)) u_sleep_sync (
      .clk(clk_slow), .rst_n(rst_n), .d(sleep_req), .q(sleep_s));

   sws_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(clk_slow), .rst_n(rst_n), .d(bus_ack), .q(ack_s));

   sws_wake_detect #(.N_IRQ(N_IRQ), .MASK_ACTIVE_HIGH(MASK_ACTIVE_HIGH)) u_wake (
      .clk_slow(clk_slow), .rst_n(rst_n), .irq_req(irq_req),
      .irq_mask(irq_mask), .wake_n(wake_n));

   sws_fsm u_fsm (
      .clk_slow(clk_slow), .rst_n(rst_n), .sleep_s(sleep_s), .ack_s(ack_s),
      .wake_n(wake_n), .state_q(state_q), .pd_q(pwr_down));

   sws_strobe #(.N_SUP(N_SUP)) u_strobe (
      .clk_slow(clk_slow), .rst_n(rst_n), .state_q(state_q),
      .sup_status(sup_status), .ref_sample(ref_sample),
      .sup_sample(sup_sample), .bus_req(bus_req), .sup_held(sup_held));

   always_comb begin
      case (state_q)
         ST_ENTER:             seq_status = STAT_ENTER;
         ST_SLEEP:             seq_status = STAT_ASLEEP;
         ST_SETTLE, ST_SAMPLE: seq_status = STAT_WAKING;
         default:              seq_status = STAT_AWAKE;
      endcase
   end

   // R4: power-down only under a held bus request
   a_r4_pd_needs_busreq: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      pwr_down |-> bus_req);

   // R9: strobes exclusive and confined to the waking state
   a_r9_strobes_exclusive: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      !(ref_sample && sup_sample));
   a_r9_strobes_in_wake: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      (ref_sample || sup_sample) |-> (seq_status == STAT_WAKING));

   // R8: bus request drops together with the supervisor strobe
   a_r8_release_with_sup: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      $fell(bus_req) |-> sup_sample);

   // R2: power-down rises only while the CPU acknowledges
   a_r2_pd_after_ack: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      $rose(pwr_down) |-> bus_ack);

   // R6: power-down falls only into the waking state
   a_r6_pd_fall_waking: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      $fell(pwr_down) |-> (seq_status == STAT_WAKING));

endmodule

// File: tb/sleep_wake_seq_tb_top.sv
module sleep_wake_seq_tb_top;

   localparam int N_IRQ = 8;
   localparam int N_SUP = 2;
   localparam longint HALF = 80;          // slow half-period in time units
   localparam longint PER  = 2 * HALF;

   logic             clk = 1'b0;
   logic             clk_slow = 1'b0;
   logic             rst_n = 1'b0;
   logic [N_IRQ-1:0] irq_req = '0;
   logic [N_IRQ-1:0] irq_mask = '0;
   logic             sleep_req = 1'b0;
   logic             bus_ack;
   logic [N_SUP-1:0] sup_status = '0;
   logic             pwr_down, ref_sample, sup_sample, bus_req;
   logic [N_SUP-1:0] sup_held;
   logic [1:0]       seq_status;
   logic             ack_block = 1'b0;

   int     n_chk = 0;
   int     n_bad = 0;
   bit     done  = 1'b0;
   int     ref_cnt = 0, sup_cnt = 0;
   longint ref_rise_t, ref_fall_t, sup_rise_t, sup_fall_t, rel_t, irq_t;

   always #2 clk = ~clk;                  // 250 MHz CPU clock
   initial begin
      #1;
      forever #(HALF) clk_slow = ~clk_slow;
   end

   sleep_wake_seq #(.N_IRQ(N_IRQ), .N_SUP(N_SUP)) dut_i (
      .clk_cpu(clk), .clk_slow(clk_slow), .rst_n(rst_n),
      .irq_req(irq_req), .irq_mask(irq_mask), .sleep_req(sleep_req),
      .bus_ack(bus_ack), .sup_status(sup_status), .pwr_down(pwr_down),
      .ref_sample(ref_sample), .sup_sample(sup_sample), .bus_req(bus_req),
      .sup_held(sup_held), .seq_status(seq_status));

   // CPU model: acknowledge follows the request one CPU clock later
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_ack <= 1'b0;
      else        bus_ack <= ack_block ? 1'b0 : bus_req;
   end

   always @(posedge ref_sample) begin ref_cnt++; ref_rise_t = $time; end
   always @(negedge ref_sample) ref_fall_t = $time;
   always @(posedge sup_sample) begin sup_cnt++; sup_rise_t = $time; end
   always @(negedge sup_sample) sup_fall_t = $time;
   always @(negedge bus_req)    rel_t = $time;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit wakes(input logic [N_IRQ-1:0] rq, input logic [N_IRQ-1:0] mk);
      return |(rq & mk);
   endfunction

   task automatic enter_sleep();
      int n;
      sleep_req = 1'b1;
      n = 0;
      while (bus_req !== 1'b1 && n < 2000) begin @(posedge clk); n++; end
      #1;
      chk(bus_req === 1'b1, "R2 bus_req rises", bus_req, 1);
      chk(seq_status == 2'b01 && pwr_down == 1'b0, "R2 entering", seq_status, 1);
      sleep_req = 1'b0;
      n = 0;
      while (pwr_down !== 1'b1 && n < 2000) begin @(posedge clk); n++; end
      #1;
      chk(pwr_down === 1'b1 && bus_ack === 1'b1, "R2 pd after ack", pwr_down, 1);
      chk(seq_status == 2'b10, "R2 asleep", seq_status, 2);
   endtask

   task automatic no_effect_window(input logic [1:0] st, input logic pd, input string req);
      int rc, sc;
      rc = ref_cnt; sc = sup_cnt;
      repeat (4) @(posedge clk_slow);
      #3;
      chk(seq_status == st, req, seq_status, st);
      chk(pwr_down == pd && bus_req == pd, req, pwr_down, pd);
      chk(ref_cnt == rc && sup_cnt == sc, req, ref_cnt + sup_cnt, rc + sc);
   endtask

   task automatic wake_run(input logic [N_IRQ-1:0] rq, input logic [N_IRQ-1:0] mk, input int off);
      int rc, sc;
      logic [N_SUP-1:0] sv;
      rc = ref_cnt; sc = sup_cnt;
      sv = N_SUP'($urandom);
      sup_status = sv;
      irq_mask = mk;
      @(posedge clk_slow);
      #(off);
      irq_req = rq;
      irq_t = $time;
      @(negedge clk_slow); #1;
      chk(pwr_down == 1'b1 && seq_status == 2'b10, "R6 still asleep at sampling edge", pwr_down, 1);
      @(posedge clk_slow); #1;
      chk(pwr_down == 1'b0, "R6 pd falls", pwr_down, 0);
      chk(seq_status == 2'b11 && ref_sample == 1'b0, "R6 waking", seq_status, 3);
      @(posedge clk_slow); #1;
      chk(ref_sample == 1'b1 && sup_sample == 1'b0 && bus_req == 1'b1, "R7 ref strobe", ref_sample, 1);
      @(negedge clk_slow); #1;
      chk(ref_sample == 1'b0 && sup_sample == 1'b1, "R8 sup strobe", sup_sample, 1);
      chk(bus_req == 1'b0, "R8 bus_req falls", bus_req, 0);
      chk(sup_held == sv, "R8 capture", sup_held, sv);
      @(posedge clk_slow); #1;
      chk(sup_sample == 1'b0 && seq_status == 2'b00, "R8 back awake", seq_status, 0);
      chk(ref_fall_t - ref_rise_t == HALF, "R7 ref width", ref_fall_t - ref_rise_t, HALF);
      chk(sup_fall_t - sup_rise_t == HALF, "R8 sup width", sup_fall_t - sup_rise_t, HALF);
      chk(ref_cnt == rc + 1 && sup_cnt == sc + 1, "R9 one strobe each", ref_cnt - rc, 1);
      chk(rel_t - irq_t >= 2 * PER && rel_t - irq_t <= 3 * PER, "R10 latency",
          rel_t - irq_t, 2 * PER);
      repeat (3) @(posedge clk); #1;
      chk(bus_ack == 1'b0, "R2 ack released", bus_ack, 0);
      sup_status = ~sv;
      @(negedge clk_slow); #1;
      chk(sup_held == sv, "R8 capture held", sup_held, sv);
      irq_req = '0;
   endtask

   function automatic int rand_off();
      int o;
      o = int'($urandom_range(0, 129));
      return (o < 65) ? o + 5 : o + 25;  // keep clear of the falling edge
   endfunction

   initial begin
      logic [N_IRQ-1:0] rq, mk;
      void'($urandom(32'h5EED));
      #3;
      chk(pwr_down == 0 && bus_req == 0 && ref_sample == 0 && sup_sample == 0,
          "R1 outputs in reset", {pwr_down, bus_req, ref_sample, sup_sample}, 0);
      chk(seq_status == 2'b00 && sup_held == '0, "R1 status in reset", seq_status, 0);
      #297;
      rst_n = 1'b1;
      repeat (2) @(posedge clk_slow); #3;
      chk(seq_status == 2'b00 && pwr_down == 0 && bus_req == 0, "R1 after reset", seq_status, 0);

      // R11: interrupts while awake
      irq_mask = '1; irq_req = 8'h81;
      no_effect_window(2'b00, 1'b0, "R11 awake irq ignored");
      irq_req = '0;

      // directed: first and last request lines
      enter_sleep();
      wake_run(8'h01, 8'h01, 10);
      enter_sleep();
      wake_run(8'h80, 8'hFF, 120);

      // R5: masked request does not wake
      enter_sleep();
      irq_mask = 8'h0F; irq_req = 8'hF0;
      no_effect_window(2'b10, 1'b1, "R5 masked ignored");
      wake_run(8'hF4, 8'h0F, 40);

      // R3: acknowledge withheld
      ack_block = 1'b1;
      sleep_req = 1'b1;
      repeat (6) @(posedge clk_slow); #3;
      sleep_req = 1'b0;
      chk(bus_req == 1'b1 && seq_status == 2'b01, "R3 entering held", seq_status, 1);
      chk(pwr_down == 1'b0, "R3 no pd without ack", pwr_down, 0);
      ack_block = 1'b0;
      repeat (5) @(posedge clk_slow); #3;
      chk(pwr_down == 1'b1 && seq_status == 2'b10, "R3 pd after late ack", pwr_down, 1);
      wake_run(8'h10, 8'h10, 100);

      // random mask and request patterns
      for (int it = 0; it < 20; it++) begin
         rq = N_IRQ'($urandom);
         mk = N_IRQ'($urandom);
         enter_sleep();
         if (!wakes(rq, mk)) begin
            irq_mask = mk; irq_req = rq;
            no_effect_window(2'b10, 1'b1, "R5 random masked");
            if (mk == '0) mk = 8'h01;
            rq = rq | (mk & ~(mk - 1'b1));
         end
         chk(wakes(rq, mk), "R5 pattern enabled", wakes(rq, mk), 1);
         wake_run(rq, mk, rand_off());
      end

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #600000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule